// File: doc/BRIEF.md
# Self-Clocked Converter Result Reader

This block sits on the host side of a three-wire link to a delta-sigma converter that produces its own serial clock. To ask for a result, the host lowers an active-low select line and, after the data line has passed through the synchronizer, reads the level on that line. A high level means a conversion is still running. In that case the reader raises select, waits a programmable number of system clocks, and asks again. A low level means a result is ready. The reader then keeps select low and the converter starts to toggle its clock.

The converter's clock and data are brought into the system clock domain. Every rising edge of the synchronized clock shifts one bit into the result word, most significant bit first. The first bit is the converter's end-of-conversion flag. A frame has 24 bits. A length input chosen per read lets the host take only the first L bits. The reader then raises select right after the L-th edge, which also makes the converter start its next conversion. Bits that were not captured read as zero. The finished word is presented with a one-cycle valid strobe. If the converter reports ready but no clock edge arrives in time, the reader gives up with a one-cycle error strobe.

Top module: `selfclk_adc_rx`

## Requirements
- R1: After reset, select is high, `word_vld`, `rx_err` and `rx_busy` are low, and `word_o` is zero.
- R2: A read request drives select low for exactly SETTLE_CYC system clocks before the data level is judged. If the level is 1 (busy), select goes high at the end of that window.
- R3: After a busy result, select stays high for exactly `poll_gap`+1 system clocks and is then lowered again for a new status check. This repeats until the converter reports ready.
- R4: When the data level is 0 (ready), select stays low. Each rising edge of the synchronized converter clock captures one data bit. The bit from edge k lands in `word_o` bit 24-k, so the end-of-conversion flag (0) lands in bit 23.
- R5: With a length of 24, the reader takes all 24 edges of the frame and pulses `word_vld` after the 24th edge.
- R6: With a length L from 1 to 23, select rises after the L-th edge and before the converter can produce edge L+1. `word_o` bits 23 down to 24-L hold the captured bits, and bits 23-L down to 0 are zero.
- R7: A length of 0, or any value above 24, is treated as 24.
- R8: `word_vld` is a single-cycle pulse that rises together with select. `word_o` changes only in a cycle where `word_vld` is high.
- R9: If no synchronized clock edge arrives within TIMEOUT system clocks of entering readout (or of the previous edge), `rx_err` pulses for one cycle and select rises in the same cycle. No word is delivered, so on a ready converter select is low for SETTLE_CYC+TIMEOUT clocks.
- R10: While `rx_busy` is high, read requests are ignored. One request yields at most one word.
- R11: The data line is ignored while select is high. Its level at those times has no effect on any later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | One-cycle request to fetch a result |
| frame_len | input | 5 | Number of bits to capture (1 to 24; other values mean 24), latched with the request |
| poll_gap | input | GAP_W | Clocks (minus one) that select stays high between status checks |
| adc_sck | input | 1 | Serial clock driven by the converter |
| adc_sdo | input | 1 | Serial data and busy flag from the converter |
| adc_cs_n | output | 1 | Active-low select to the converter |
| word_o | output | 24 | Last captured word, MSB first, zero-filled |
| word_vld | output | 1 | One-cycle strobe marking a new `word_o` |
| rx_err | output | 1 | One-cycle strobe when no clock edge arrived in time |
| rx_busy | output | 1 | High while a read is in progress |

## Verification
Some rules are checked by assertions on every cycle. Select must be high when the reader is idle or waiting between polls, and low while it shifts bits. Every busy result, finished frame and timeout must raise select on the next clock. No capture may run past the latched length, and the valid and error strobes must stay single-cycle and never overlap. Other behaviour can only be shown by the bench's scenarios, using a behavioural converter model. That includes the exact lengths of the select-low and select-high windows, the zero-fill for each length, and the edge count the converter actually produced before an early abort. It also includes requests that arrive mid-frame, and the fact that data toggled while select is high is never captured.

// File: rtl/adcrx_pkg.sv
package adcrx_pkg;

  localparam int FRAME_BITS = 24;
  localparam int IDX_W      = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_GAP    = 2'd2,
    ST_SHIFT  = 2'd3
  } rx_state_t;

  // Lengths outside 1..FRAME_BITS select a full frame.
  function automatic logic [IDX_W-1:0] eff_len(input logic [IDX_W-1:0] req);
    if (req == '0 || req > IDX_W'(FRAME_BITS)) return IDX_W'(FRAME_BITS);
    return req;
  endfunction

  // Place bit b at frame position pos, counted from the MSB.
  function automatic logic [FRAME_BITS-1:0] put_bit(input logic [FRAME_BITS-1:0] w,
                                                    input logic [IDX_W-1:0]      pos,
                                                    input logic                  b);
    logic [FRAME_BITS-1:0] r;
    r = w;
    r[IDX_W'(FRAME_BITS-1) - pos] = b;
    return r;
  endfunction

endpackage

// File: rtl/adcrx_sync.sv
module adcrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdo_in,
  output logic sdo_s,
  output logic sck_rise
);

  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] sdo_p;
  logic              sck_q;

  // Clock and data share one pipeline depth so each bit stays aligned with its edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '1;
      sdo_p <= '1;
      sck_q <= 1'b1;
    end else begin
      sck_p[0] <= sck_in;
      sdo_p[0] <= sdo_in;
      for (int i = 1; i < STAGES; i++) begin
        sck_p[i] <= sck_p[i-1];
        sdo_p[i] <= sdo_p[i-1];
      end
      sck_q <= sck_p[STAGES-1];
    end
  end

  assign sdo_s    = sdo_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise); // R4

endmodule

// File: rtl/adcrx_shift.sv
module adcrx_shift
  import adcrx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cap,
  input  logic                  bit_in,
  input  logic [IDX_W-1:0]      len_eff,
  output logic [FRAME_BITS-1:0] frame_next,
  output logic                  last
);

  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      nbit;

  assign frame_next = put_bit(sh, nbit, bit_in);
  assign last       = cap && ((nbit + 1'b1) == len_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      nbit <= '0;
    end else if (clr) begin
      sh   <= '0;
      nbit <= '0;
    end else if (cap) begin
      sh   <= frame_next;
      nbit <= nbit + 1'b1;
    end
  end

  AST_CAPTURE_IN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (nbit < len_eff)); // R6

endmodule

// File: rtl/adcrx_ctrl.sv
module adcrx_ctrl
  import adcrx_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int TIMEOUT    = 256,
  parameter int GAP_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] len_req,
  input  logic [GAP_W-1:0] poll_gap,
  input  logic             sdo_s,
  input  logic             sck_rise,
  input  logic             last,
  output logic             cs_n,
  output logic             cap,
  output logic             clr,
  output logic             tmo_hit,
  output logic [IDX_W-1:0] len_q,
  output logic             active
);

  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam int CNT_W = (TMO_W > GAP_W) ? TMO_W : GAP_W;

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             in_shift;
  logic             settle_end;
  logic             busy_seen;

  assign in_shift   = (state == ST_SHIFT);
  assign settle_end = (state == ST_SETTLE) && (cnt == '0);
  assign busy_seen  = settle_end && sdo_s;
  assign cap        = in_shift && sck_rise;
  assign tmo_hit    = in_shift && !sck_rise && (cnt == '0);
  assign clr        = !in_shift;
  assign active     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      cs_n  <= 1'b1;
      len_q <= IDX_W'(FRAME_BITS);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rd_req) begin
            state <= ST_SETTLE;
            cnt   <= CNT_W'(SETTLE_CYC - 1);
            cs_n  <= 1'b0;
            len_q <= eff_len(len_req);
          end
        end
        ST_SETTLE: begin
          if (cnt == '0) begin
            if (sdo_s) begin
              state <= ST_GAP;
              cnt   <= CNT_W'(poll_gap);
              cs_n  <= 1'b1;
            end else begin
              state <= ST_SHIFT;
              cnt   <= CNT_W'(TIMEOUT - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            state <= ST_SETTLE;
            cnt   <= CNT_W'(SETTLE_CYC - 1);
            cs_n  <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (sck_rise) begin
            cnt <= CNT_W'(TIMEOUT - 1);
            if (last) begin
              state <= ST_IDLE;
              cs_n  <= 1'b1;
            end
          end else if (cnt == '0) begin
            state <= ST_IDLE;
            cs_n  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> cs_n); // R1
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_seen |=> (cs_n && state == ST_GAP)); // R2
  AST_GAP_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> cs_n); // R3
  AST_SHIFT_SELECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_shift |-> !cs_n); // R4
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cs_n && state == ST_IDLE)); // R6
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (cs_n && state == ST_IDLE)); // R9
  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(len_q)); // R10

endmodule

// File: rtl/selfclk_adc_rx.sv
module selfclk_adc_rx
  import adcrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT     = 256,
  parameter int GAP_W       = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req,
  input  logic [IDX_W-1:0]      frame_len,
  input  logic [GAP_W-1:0]      poll_gap,
  input  logic                  adc_sck,
  input  logic                  adc_sdo,
  output logic                  adc_cs_n,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  word_vld,
  output logic                  rx_err,
  output logic                  rx_busy
);

  // Events shared between the sub-blocks and the assertions
  logic                  sdo_s;
  logic                  sck_rise;
  logic                  cap;
  logic                  clr;
  logic                  frame_done;
  logic                  tmo_hit;
  logic [IDX_W-1:0]      len_q;
  logic [FRAME_BITS-1:0] frame_next;

  adcrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_in   (adc_sck),
    .sdo_in   (adc_sdo),
    .sdo_s    (sdo_s),
    .sck_rise (sck_rise)
  );

  adcrx_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .TIMEOUT    (TIMEOUT),
    .GAP_W      (GAP_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .len_req  (frame_len),
    .poll_gap (poll_gap),
    .sdo_s    (sdo_s),
    .sck_rise (sck_rise),
    .last     (frame_done),
    .cs_n     (adc_cs_n),
    .cap      (cap),
    .clr      (clr),
    .tmo_hit  (tmo_hit),
    .len_q    (len_q),
    .active   (rx_busy)
  );

  adcrx_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .cap        (cap),
    .bit_in     (sdo_s),
    .len_eff    (len_q),
    .frame_next (frame_next),
    .last       (frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o   <= '0;
      word_vld <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      word_vld <= frame_done;
      rx_err   <= tmo_hit;
      if (frame_done) word_o <= frame_next;
    end
  end

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R8
  AST_VLD_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> adc_cs_n); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_o)); // R8
  AST_ERR_NOT_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && rx_err)); // R9

endmodule

// File: tb/test_selfclk_adc_rx.sv
`timescale 1ns/1ps
module test_selfclk_adc_rx;

  localparam int S    = 4;
  localparam int TMO  = 40;
  localparam int GAP  = 20;
  localparam int CONV = 120;
  localparam int TEOC = 12;
  localparam int HP   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [4:0]  frame_len = 5'd24;
  logic [15:0] poll_gap = 16'(GAP);
  logic        adc_sck = 1'b1;
  logic        adc_sdo = 1'b1;
  logic        adc_cs_n;
  logic [23:0] word_o;
  logic        word_vld;
  logic        rx_err;
  logic        rx_busy;

  always #2.5 clk = ~clk;

  selfclk_adc_rx #(
    .SYNC_STAGES (2),
    .SETTLE_CYC  (S),
    .TIMEOUT     (TMO),
    .GAP_W       (16)
  ) i_selfclk_adc_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .frame_len (frame_len),
    .poll_gap  (poll_gap),
    .adc_sck   (adc_sck),
    .adc_sdo   (adc_sdo),
    .adc_cs_n  (adc_cs_n),
    .word_o    (word_o),
    .word_vld  (word_vld),
    .rx_err    (rx_err),
    .rx_busy   (rx_busy)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural converter model
  int          conv_left = 0;
  bit          mute = 1'b0;
  int          wait_c = 0;
  bit          in_frame = 1'b0;
  int          edges = 0;
  int          ph = 0;
  int          last_edges = -1;
  bit          junk = 1'b0;
  logic [23:0] frame_bits = 24'h0;

  always @(negedge clk) begin
    if (!rst_n) begin
      adc_sck = 1'b1;
      adc_sdo = 1'b1;
    end else begin
      if (conv_left > 0) conv_left--;
      if (adc_cs_n) begin
        if (in_frame) begin
          in_frame   = 1'b0;
          last_edges = edges;
          conv_left  = CONV;
        end
        adc_sck = 1'b1;
        junk    = ~junk;
        adc_sdo = junk;   // undefined while deselected
        wait_c  = 0;
      end else if (!in_frame) begin
        if (conv_left > 0) begin
          adc_sdo = 1'b1;
        end else begin
          adc_sdo = frame_bits[23];
          adc_sck = 1'b0;
          if (!mute) begin
            wait_c++;
            if (wait_c >= TEOC) begin
              in_frame = 1'b1;
              edges    = 1;
              ph       = 0;
              adc_sck  = 1'b1;
            end
          end
        end
      end else begin
        ph++;
        if (ph == HP) begin
          ph = 0;
          if (adc_sck) begin
            adc_sck = 1'b0;
            adc_sdo = frame_bits[23-edges];
          end else begin
            adc_sck = 1'b1;
            edges++;
            if (edges == 24) begin
              in_frame   = 1'b0;
              last_edges = 24;
              conv_left  = CONV;
            end
          end
        end
      end
    end
  end

  // Reference monitor, compared every clock
  logic [23:0] exp_q[$];
  int          low_q[$];
  int          high_q[$];
  int          cs_run = 0;
  logic        prev_cs = 1'b1;
  logic [23:0] held = 24'h0;
  int          vld_seen = 0;
  int          err_seen = 0;
  bit          exp_err = 1'b0;

  function automatic logic [23:0] want_word(input logic [23:0] f, input int len);
    int L;
    L = (len < 1 || len > 24) ? 24 : len;
    return f & (~24'h0 << (24 - L));
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_cs_n == prev_cs) cs_run++;
      else begin
        if (prev_cs) high_q.push_back(cs_run);
        else         low_q.push_back(cs_run);
        cs_run  = 1;
        prev_cs = adc_cs_n;
      end
      if (word_vld) begin
        vld_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word", word_o, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(word_o == e, "R4/R6 captured word", word_o, e);
        end
        chk(adc_cs_n == 1'b1, "R8 select high with valid", adc_cs_n, 1);
      end else if (word_o != held) begin
        chk(1'b0, "R8 word changed without valid", word_o, held);
      end
      held = word_o;
      if (rx_err) begin
        err_seen++;
        if (!exp_err) chk(1'b0, "R9 unexpected error", 1, 0);
      end
    end
  end

  task automatic pulse_req();
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    @(negedge clk);
    low_q.delete();
    high_q.delete();
  endtask

  task automatic run_read(input logic [22:0] d, input int len);
    int n0;
    frame_bits = {1'b0, d};
    exp_q.push_back(want_word({1'b0, d}, len));
    frame_len = 5'(len);
    n0 = vld_seen;
    pulse_req();
    for (int i = 0; i < 20000 && vld_seen == n0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(vld_seen == n0 + 1, "R5 one word per read", vld_seen - n0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 select in reset", adc_cs_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1 && word_vld == 1'b0 && rx_err == 1'b0 && rx_busy == 1'b0,
        "R1 reset outputs", {adc_cs_n, word_vld, rx_err, rx_busy}, 4'b1000);
    chk(word_o == 24'h0, "R1 reset word", word_o, 0);

    // R5: full frame on a ready converter
    run_read(23'h5A3C1E, 24);
    chk(last_edges == 24, "R5 edges in full frame", last_edges, 24);
    chk(rx_busy == 1'b0, "R5 idle after frame", rx_busy, 0);

    // R2/R3/R6: converter busy, short frame
    run_read(23'h7FFFFF, 8);
    chk(low_q.size() > 1 && low_q[0] == S, "R2 status window length", low_q[0], S);
    chk(high_q.size() > 0 && high_q[0] == GAP + 1, "R3 poll gap length", high_q[0], GAP + 1);
    chk(last_edges == 8, "R6 abort after edge 8", last_edges, 8);

    // R4/R6: only the flag bit
    run_read(23'h7FFFFF, 1);
    chk(last_edges == 1, "R6 abort after edge 1", last_edges, 1);

    run_read(23'h2AAAAA, 13);
    chk(last_edges == 13, "R6 abort after edge 13", last_edges, 13);

    // R7: out-of-range lengths
    run_read(23'h123456, 0);
    chk(last_edges == 24, "R7 length 0 reads all", last_edges, 24);
    run_read(23'h654321, 30);
    chk(last_edges == 24, "R7 length 30 reads all", last_edges, 24);

    // R10: request during a frame is ignored
    begin
      int n0;
      frame_bits = {1'b0, 23'h0F0F0F};
      exp_q.push_back(want_word({1'b0, 23'h0F0F0F}, 24));
      frame_len = 5'd24;
      n0 = vld_seen;
      pulse_req();
      for (int i = 0; i < 20000 && !in_frame; i++) @(negedge clk);
      repeat (20) @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
      repeat (600) @(negedge clk);
      chk(vld_seen == n0 + 1, "R10 single word", vld_seen - n0, 1);
      chk(adc_cs_n == 1'b1 && rx_busy == 1'b0, "R10 idle afterwards", {adc_cs_n, rx_busy}, 2'b10);
    end

    // R9: ready converter that never clocks
    begin
      int n0;
      int e0;
      repeat (CONV + 20) @(negedge clk);
      mute = 1'b1;
      exp_err = 1'b1;
      n0 = vld_seen;
      e0 = err_seen;
      frame_len = 5'd24;
      pulse_req();
      for (int i = 0; i < 2000 && err_seen == e0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(err_seen == e0 + 1, "R9 one error pulse", err_seen - e0, 1);
      chk(vld_seen == n0, "R9 no word on timeout", vld_seen - n0, 0);
      chk(low_q.size() > 0 && low_q[0] == S + TMO, "R9 select low window", low_q[0], S + TMO);
      chk(adc_cs_n == 1'b1 && rx_busy == 1'b0, "R9 released", {adc_cs_n, rx_busy}, 2'b10);
      exp_err = 1'b0;
      mute = 1'b0;
    end

    // R11: data toggling while deselected never reaches the word
    repeat (50) @(negedge clk);
    run_read(23'h0000F1, 24);
    chk(word_o == want_word({1'b0, 23'h0000F1}, 24), "R11 word after idle toggling",
        word_o, want_word({1'b0, 23'h0000F1}, 24));

    chk(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule